// File: doc/BRIEF.md
# Video shift mode control registers

This block is the register group that selects the pixel format of a programmable video shifter. It stores a two-bit legacy shift mode, an extended shift mode word, a line width, a video mode word and a two-bit sync mode. It also presents a read-only view of the attached monitor type. Each register is written through a simple select/data write port, and every register value is always visible on its own output.

A write to the legacy shift mode also loads the line width and video mode registers. The values it loads depend on the monitor type present at the moment of the write. The block remembers whether the legacy or the extended mode register was written last. It combines that history with both mode values to give the effective bits per pixel. From the video mode word it decodes the clock cycles per pixel and flags the one encoding that is not valid. Timing generation and pixel output belong to other blocks.

Register select codes on `wr_sel_i`: 0 monitor, 1 sync, 2 legacy mode, 3 extended mode, 4 line width, 5 video mode. All registers update on the rising clock edge that samples the write. The decoded outputs follow the stored values combinationally.

Top module: `vshift_mode_ctrl`

## Requirements
- R1: After reset the palette-source flag is clear, and the line width, video mode, sync, legacy mode and extended mode registers are all zero.
- R2: `mon_reg_o` carries `monitor_i` in bits 7:6 (00 mono, 01 RGB, 10 VGA, 11 TV) with bits 5:0 zero, and writes with select 0 change nothing.
- R3: A sync write keeps only data bits 1:0; bits 7:2 of `sync_o` are always zero.
- R4: A legacy write keeps only data bits 1:0 and sets the palette-source flag.
- R5: A legacy write of mode 0 loads line width 0x50 and video mode 0x5 on VGA, else 0x0. Mode 1 loads 0x50 and video mode 0x9 on VGA, else 0x4. Mode 3 loads 0x50 and 0x0 on any monitor.
- R6: A legacy write of mode 2 loads line width 0x28 and video mode 0x0 on mono, 0x8 on VGA, and 0x6 on RGB or TV.
- R7: Any write with select 3 stores the full data word in the extended mode register and clears the palette-source flag.
- R8: Bits per pixel resolve in this priority order. Extended bit 10 gives 1, then bit 8 gives 16, then bit 4 gives 8. Otherwise the result is 4 when the flag is clear, and 4, 2, 1, 1 for legacy modes 0, 1, 2, 3 when the flag is set.
- R9: Video mode bits 3:2 give cycles per pixel: 00 gives 4, 01 gives 2, 10 or 11 give 1. `mode_bad_o` is high exactly for 11.
- R10: A direct line width write keeps the low LW_W data bits. A direct video mode write keeps the low VM_W data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | DATA_W | Write data |
| monitor_i | input | 2 | Attached monitor type |
| mon_reg_o | output | 8 | Monitor register view |
| sync_o | output | 8 | Sync mode register |
| legacy_o | output | 8 | Legacy shift mode register |
| ext_mode_o | output | DATA_W | Extended shift mode register |
| line_width_o | output | LW_W | Line width in words |
| vid_mode_o | output | VM_W | Video mode register |
| legacy_pal_o | output | 1 | Legacy mode written last |
| bpp_o | output | 5 | Effective bits per pixel (1, 2, 4, 8, 16) |
| cyc_per_pix_o | output | 3 | Cycles per pixel (1, 2, 4) |
| mode_bad_o | output | 1 | Video mode bits 3:2 equal 11 |

## Verification
The bench builds the block with its default widths: a 16-bit data word, a 10-bit line width and a 16-bit video mode. At these widths, writing all ones shows that the line width keeps exactly ten bits and that every extended mode bit is stored. The full 16-bit word also reaches extended bits 10, 8 and 4 together, so each level of the depth priority can be set against the levels below it. The bench then sweeps every legacy mode against all four monitor types to cover the complete side-load table.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic [2:0] {
    SEL_MON   = 3'd0,
    SEL_SYNC  = 3'd1,
    SEL_LEG   = 3'd2,
    SEL_EXT   = 3'd3,
    SEL_LWID  = 3'd4,
    SEL_VMODE = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    MON_MONO = 2'd0,
    MON_RGB  = 2'd1,
    MON_VGA  = 2'd2,
    MON_TV   = 2'd3
  } mon_e;

  function automatic logic [15:0] leg_width(input logic [1:0] mode);
    return (mode == 2'd2) ? 16'h0028 : 16'h0050;
  endfunction

  function automatic logic [15:0] leg_vmode(input logic [1:0] mode, input mon_e mon);
    logic [15:0] v;
    unique case (mode)
      2'd0:    v = (mon == MON_VGA) ? 16'h0005 : 16'h0000;
      2'd1:    v = (mon == MON_VGA) ? 16'h0009 : 16'h0004;
      2'd2:    v = (mon == MON_MONO) ? 16'h0000 :
                   (mon == MON_VGA)  ? 16'h0008 : 16'h0006;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/vsm_regs.sv
module vsm_regs
  import vsm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LW_W   = 10,
  parameter int VM_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        monitor_i,
  output logic [1:0]        sync_q_o,
  output logic [1:0]        leg_q_o,
  output logic [DATA_W-1:0] ext_q_o,
  output logic [LW_W-1:0]   lw_q_o,
  output logic [VM_W-1:0]   vm_q_o,
  output logic              leg_pal_q_o
);
  reg_sel_e    sel;
  logic [15:0] side_lw, side_vm;

  assign sel     = reg_sel_e'(wr_sel_i);
  assign side_lw = leg_width(wr_data_i[1:0]);
  assign side_vm = leg_vmode(wr_data_i[1:0], mon_e'(monitor_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q_o    <= '0;
      leg_q_o     <= '0;
      ext_q_o     <= '0;
      lw_q_o      <= '0;
      vm_q_o      <= '0;
      leg_pal_q_o <= 1'b0;
    end else if (wr_en_i) begin
      unique case (sel)
        SEL_SYNC:  sync_q_o <= wr_data_i[1:0];
        SEL_LEG: begin
          leg_q_o     <= wr_data_i[1:0];
          leg_pal_q_o <= 1'b1;
          lw_q_o      <= LW_W'(side_lw);
          vm_q_o      <= VM_W'(side_vm);
        end
        SEL_EXT: begin
          ext_q_o     <= wr_data_i;
          leg_pal_q_o <= 1'b0;
        end
        SEL_LWID:  lw_q_o <= wr_data_i[LW_W-1:0];
        SEL_VMODE: vm_q_o <= VM_W'(wr_data_i);
        default: ;  // monitor view is read-only
      endcase
    end
  end
endmodule

// File: rtl/vsm_depth_dec.sv
module vsm_depth_dec #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ext_i,
  input  logic [1:0]        leg_i,
  input  logic              leg_pal_i,
  output logic [4:0]        bpp_o
);
  always_comb begin
    if (ext_i[10])      bpp_o = 5'd1;
    else if (ext_i[8])  bpp_o = 5'd16;
    else if (ext_i[4])  bpp_o = 5'd8;
    else if (!leg_pal_i) bpp_o = 5'd4;
    else begin
      unique case (leg_i)
        2'd0:    bpp_o = 5'd4;
        2'd1:    bpp_o = 5'd2;
        default: bpp_o = 5'd1;
      endcase
    end
  end
endmodule

// File: rtl/vsm_pix_rate.sv
module vsm_pix_rate (
  input  logic [1:0] rate_i,
  output logic [2:0] cyc_o,
  output logic       bad_o
);
  always_comb begin
    unique case (rate_i)
      2'b00:   cyc_o = 3'd4;
      2'b01:   cyc_o = 3'd2;
      default: cyc_o = 3'd1;
    endcase
    bad_o = &rate_i;
  end
endmodule

// File: rtl/vshift_mode_ctrl.sv
module vshift_mode_ctrl #(
  parameter int DATA_W = 16,
  parameter int LW_W   = 10,
  parameter int VM_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        monitor_i,
  output logic [7:0]        mon_reg_o,
  output logic [7:0]        sync_o,
  output logic [7:0]        legacy_o,
  output logic [DATA_W-1:0] ext_mode_o,
  output logic [LW_W-1:0]   line_width_o,
  output logic [VM_W-1:0]   vid_mode_o,
  output logic              legacy_pal_o,
  output logic [4:0]        bpp_o,
  output logic [2:0]        cyc_per_pix_o,
  output logic              mode_bad_o
);
  logic [1:0] sync_q, leg_q;

  vsm_regs #(.DATA_W(DATA_W), .LW_W(LW_W), .VM_W(VM_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .monitor_i   (monitor_i),
    .sync_q_o    (sync_q),
    .leg_q_o     (leg_q),
    .ext_q_o     (ext_mode_o),
    .lw_q_o      (line_width_o),
    .vm_q_o      (vid_mode_o),
    .leg_pal_q_o (legacy_pal_o)
  );

  vsm_depth_dec #(.DATA_W(DATA_W)) u_depth (
    .ext_i     (ext_mode_o),
    .leg_i     (leg_q),
    .leg_pal_i (legacy_pal_o),
    .bpp_o     (bpp_o)
  );

  vsm_pix_rate u_rate (
    .rate_i (vid_mode_o[3:2]),
    .cyc_o  (cyc_per_pix_o),
    .bad_o  (mode_bad_o)
  );

  assign mon_reg_o = {monitor_i, 6'b0};
  assign sync_o    = {6'b0, sync_q};
  assign legacy_o  = {6'b0, leg_q};
endmodule

// File: rtl/vshift_mode_chk.sv
module vshift_mode_chk #(
  parameter int DATA_W = 16,
  parameter int LW_W   = 10,
  parameter int VM_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [7:0]        sync_o,
  input logic [7:0]        legacy_o,
  input logic [LW_W-1:0]   line_width_o,
  input logic              legacy_pal_o,
  input logic [4:0]        bpp_o,
  input logic [2:0]        cyc_per_pix_o,
  input logic              mode_bad_o
);
  logic leg_wr, ext_wr;
  assign leg_wr = wr_en_i && wr_sel_i == 3'd2;
  assign ext_wr = wr_en_i && wr_sel_i == 3'd3;

  // R4
  leg_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_wr |=> legacy_pal_o);
  // R7
  ext_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr |=> !legacy_pal_o);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(leg_wr || ext_wr) |=> $stable(legacy_pal_o));
  // R3
  sync_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o[7:2] == 6'd0);
  // R5
  leg_width_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_wr |=> line_width_o == ((legacy_o[1:0] == 2'd2) ? LW_W'(16'h28) : LW_W'(16'h50)));
  // R8
  bpp_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bpp_o) == 1);
  // R9
  bad_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_bad_o |-> cyc_per_pix_o == 3'd1);
endmodule

bind vshift_mode_ctrl vshift_mode_chk #(.DATA_W(DATA_W), .LW_W(LW_W), .VM_W(VM_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_sel_i      (wr_sel_i),
  .wr_data_i     (wr_data_i),
  .sync_o        (sync_o),
  .legacy_o      (legacy_o),
  .line_width_o  (line_width_o),
  .legacy_pal_o  (legacy_pal_o),
  .bpp_o         (bpp_o),
  .cyc_per_pix_o (cyc_per_pix_o),
  .mode_bad_o    (mode_bad_o)
);

// File: tb/vshift_mode_ctrl_tb.sv
`timescale 1ns/1ps
module vshift_mode_ctrl_tb;
  localparam int DATA_W = 16;
  localparam int LW_W   = 10;
  localparam int VM_W   = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        monitor = 2'd0;
  logic [7:0]        mon_reg, sync_r, leg_r;
  logic [DATA_W-1:0] ext_r;
  logic [LW_W-1:0]   lw_r;
  logic [VM_W-1:0]   vm_r;
  logic              pal;
  logic [4:0]        bpp;
  logic [2:0]        cyc;
  logic              bad;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vshift_mode_ctrl #(.DATA_W(DATA_W), .LW_W(LW_W), .VM_W(VM_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .monitor_i(monitor), .mon_reg_o(mon_reg),
    .sync_o(sync_r), .legacy_o(leg_r), .ext_mode_o(ext_r),
    .line_width_o(lw_r), .vid_mode_o(vm_r), .legacy_pal_o(pal),
    .bpp_o(bpp), .cyc_per_pix_o(cyc), .mode_bad_o(bad));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] exp_vm(input int mode, input int mon);
    case (mode)
      0: return (mon == 2) ? 16'h5 : 16'h0;
      1: return (mon == 2) ? 16'h9 : 16'h4;
      2: return (mon == 0) ? 16'h0 : (mon == 2) ? 16'h8 : 16'h6;
      default: return 16'h0;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 flag", pal, 0);
    chk("R1 lw", lw_r, 0);
    chk("R1 vm", vm_r, 0);
    chk("R1 sync", sync_r, 0);
    chk("R1 legacy", leg_r, 0);
    chk("R1 ext", ext_r, 0);
    chk("R8 reset bpp", bpp, 4);
  endtask

  task automatic t_monitor();
    monitor = 2'd2;
    @(negedge clk);
    chk("R2 view", mon_reg, 8'h80);
    wr(3'd0, 16'hFFFF);
    chk("R2 write ignored", mon_reg, 8'h80);
    monitor = 2'd3;
    @(negedge clk);
    chk("R2 view tv", mon_reg, 8'hC0);
  endtask

  task automatic t_sync();
    wr(3'd1, 16'hFFFE);
    chk("R3 mask", sync_r, 8'h02);
    wr(3'd1, 16'h00FF);
    chk("R3 mask all", sync_r, 8'h03);
  endtask

  task automatic t_legacy_sweep();
    for (int mon = 0; mon < 4; mon++) begin
      for (int m = 0; m < 4; m++) begin
        monitor = 2'(mon);
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'hA8 | 16'(m));
        chk("R4 kept bits", leg_r, 32'(m));
        chk("R4 flag set", pal, 1);
        if (m == 2) begin
          chk("R6 lw", lw_r, 32'h28);
          chk("R6 vm", vm_r, exp_vm(m, mon));
        end else begin
          chk("R5 lw", lw_r, 32'h50);
          chk("R5 vm", vm_r, exp_vm(m, mon));
        end
        chk("R8 legacy bpp", bpp, (m == 0) ? 4 : (m == 1) ? 2 : 1);
      end
    end
  endtask

  task automatic t_ext_priority();
    wr(3'd3, 16'hFFFF);
    chk("R7 full word", ext_r, 16'hFFFF);
    chk("R7 flag clear", pal, 0);
    chk("R8 bit10 wins", bpp, 1);
    wr(3'd3, 16'h0110);
    chk("R8 bit8 over bit4", bpp, 16);
    wr(3'd3, 16'h0010);
    chk("R8 bit4", bpp, 8);
    wr(3'd2, 16'h0001);
    chk("R8 ext bits beat flag", bpp, 8);
    wr(3'd3, 16'h0000);
    chk("R8 flag clear gives 4", bpp, 4);
    wr(3'd2, 16'h0002);
    chk("R8 legacy after ext", bpp, 1);
  endtask

  task automatic t_rate();
    wr(3'd5, 16'h0000);
    chk("R9 cyc 00", cyc, 4); chk("R9 ok 00", bad, 0);
    wr(3'd5, 16'h0004);
    chk("R9 cyc 01", cyc, 2); chk("R9 ok 01", bad, 0);
    wr(3'd5, 16'h0008);
    chk("R9 cyc 10", cyc, 1); chk("R9 ok 10", bad, 0);
    wr(3'd5, 16'h000C);
    chk("R9 cyc 11", cyc, 1); chk("R9 bad 11", bad, 1);
  endtask

  task automatic t_direct();
    wr(3'd4, 16'hFFFF);
    chk("R10 lw mask", lw_r, 32'h3FF);
    wr(3'd5, 16'hA5C3);
    chk("R10 vm word", vm_r, 32'hA5C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_monitor();
    t_sync();
    t_legacy_sweep();
    t_ext_priority();
    t_rate();
    t_direct();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule